// File: doc/BRIEF.md
# Grayscale Dither Lookup Engine

This block turns a stream of 3-bit gray levels into one on/off drive bit per pixel for a monochrome LCD panel. Intermediate shades come from spatio-temporal dithering: each level owns a small programmable pattern. The pattern is indexed by where the pixel sits horizontally and vertically, and by which frame is being shown. The block keeps modulo-3 and modulo-4 versions of a horizontal (per pixel), a vertical (per line) and a frame position counter. Every gray level chooses, per dimension, which of the two moduli it follows.

Software fills a table of 32 words through a simple write port. The table holds four banks of eight entries, one entry per level in each bank. The bank in use at any moment is picked by the frame count that the level has chosen. Each entry carries a 4×4 on-pattern, and the entry in bank 0 also carries the three modulus selects for its level. Panel timing, pixel buffering and bus decoding belong to the surrounding logic.

Top module: `gray_dither`

## Requirements
- R1: A synchronous active-high `rst` clears `pix_on`, all six position counters and every table word to zero. Until it is written, any level therefore yields 0.
- R2: `pix_on` is registered. One clock after a cycle with `pix_valid` high, it shows the lookup result for that pixel. One clock after a cycle with `pix_valid` low, it is 0.
- R3: Each valid pixel advances the horizontal counters: one counts 0,1,2,0… and the other 0,1,2,3,0…. The lookup for a pixel uses the counts from before its own advance.
- R4: A `line_end` pulse returns both horizontal counters to 0 and advances both vertical counters by one, modulo 3 and modulo 4.
- R5: A `frame_end` pulse advances both frame counters by one, modulo 3 and modulo 4.
- R6: Write addresses are byte offsets. `wr_addr[6:5]` selects the bank, `wr_addr[4:2]` selects the level, and `wr_addr[1:0]` is ignored. Level n of bank k therefore sits at k×0x20 + n×4.
- R7: In an entry, bits [15:0] are the on-pattern, and bit {v,h} gives the result for vertical count v and horizontal count h. Bits 16, 17 and 18 of the level's bank-0 entry choose modulo 3 (1) or modulo 4 (0) for horizontal, vertical and frame. These bits are ignored in banks 1–3, and bits [31:19] are ignored everywhere.
- R8: The bank read for a pixel equals the level's chosen frame count. A level on the modulo-3 frame counter never reads bank 3.
- R9: A level whose entries in all four banks are all zeros never drives the pixel on.
- R10: A level whose entries in all four banks are all ones always drives the pixel on, whatever the counters hold.
- R11: A table write takes effect for pixels presented on the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 7 | Table byte address (bank, level, ignored low bits) |
| wr_data | input | 32 | Table write data |
| pix_valid | input | 1 | Pixel value present this cycle |
| pix_val | input | 3 | Gray level of the pixel |
| line_end | input | 1 | End-of-line pulse |
| frame_end | input | 1 | End-of-frame pulse |
| pix_on | output | 1 | Registered on/off drive bit |

## Verification
The bench keeps its own position counts and a shadow copy of the table. It checks every pixel against a lookup computed from the requirements, so a design with a wrong modulus shows its error on the pattern positions. The same holds for a design that forgets to clear horizontal counts at line end, which lights the wrong columns after a short line. A design that reads the modulus bits from the wrong bank diverges as soon as banks 1–3 are given junk high bits. A design that lets the modulo-3 frame counter reach bank 3 turns on a level whose bank 3 holds ones in frames where it must stay dark. Idle cycles are sampled to catch an output that lingers high. Overwriting a level from ones to zeros, with the low address bits set, exposes a stale table and a misdecoded address.

// File: rtl/gray_dither.sv
module gray_dither #(
  parameter int PIX_W  = 3,
  parameter int DATA_W = 32,
  localparam int LEVELS   = 1 << PIX_W,
  localparam int BANKS    = 4,
  localparam int BANK_W   = 2,
  localparam int PAT_W    = 16,
  localparam int BANK_LSB = PIX_W + 2,
  localparam int ADDR_W   = BANK_LSB + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_val,
  input  logic              line_end,
  input  logic              frame_end,
  output logic              pix_on
);

  logic [PAT_W-1:0] pat  [BANKS][LEVELS];
  logic [2:0]       mode [LEVELS];
  logic [1:0]       h3, h4, v3, v4, f3, f4;

  function automatic logic [1:0] inc3(input logic [1:0] x);
    return (x == 2'd2) ? 2'd0 : x + 2'd1;
  endfunction

  wire [BANK_W-1:0] wbank = wr_addr[BANK_LSB +: BANK_W];
  wire [PIX_W-1:0]  wlvl  = wr_addr[2 +: PIX_W];

  wire [2:0] m  = mode[pix_val];
  wire [1:0] hs = m[0] ? h3 : h4;
  wire [1:0] vs = m[1] ? v3 : v4;
  wire [1:0] fs = m[2] ? f3 : f4;
  wire       hit = pat[fs][pix_val][{vs, hs}];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BANKS; b++)
        for (int l = 0; l < LEVELS; l++)
          pat[b][l] <= '0;
      for (int l = 0; l < LEVELS; l++)
        mode[l] <= '0;
    end else if (wr_en) begin
      pat[wbank][wlvl] <= wr_data[PAT_W-1:0];
      if (wbank == '0)
        mode[wlvl] <= wr_data[PAT_W +: 3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h3 <= '0; h4 <= '0;
    end else if (line_end) begin
      h3 <= '0; h4 <= '0;
    end else if (pix_valid) begin
      h3 <= inc3(h3); h4 <= h4 + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v3 <= '0; v4 <= '0;
    end else if (line_end) begin
      v3 <= inc3(v3); v4 <= v4 + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f3 <= '0; f4 <= '0;
    end else if (frame_end) begin
      f3 <= inc3(f3); f4 <= f4 + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pix_on <= 1'b0;
    else     pix_on <= pix_valid & hit;
  end

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !pix_on);

  // R3
  h3_range_chk: assert property (@(posedge clk) disable iff (rst)
    h3 != 2'd3);

  // R4
  line_adv_chk: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (h4 == 2'd0) && (v4 == $past(v4) + 2'd1));

  // R5
  frame_adv_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (f4 == $past(f4) + 2'd1) && (f3 != 2'd3));

  // R8
  no_bank3_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && m[2]) |-> fs != 2'd3);

endmodule

// File: tb/test_gray_dither.sv
`timescale 1ns/1ps
module test_gray_dither;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic pix_valid = 1'b0;
  logic [2:0] pix_val = '0;
  logic line_end = 1'b0;
  logic frame_end = 1'b0;
  logic pix_on;

  int checks = 0;
  int failures = 0;
  int hc = 0, vc = 0, fc = 0;
  logic [31:0] sh [4][8];

  always #4 clk = ~clk;

  gray_dither i_gray_dither (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_valid(pix_valid), .pix_val(pix_val), .line_end(line_end),
    .frame_end(frame_end), .pix_on(pix_on)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: pix_on=%0b expected=%0b (h=%0d v=%0d f=%0d)", req, act, exp, hc, vc, fc);
    end
  endtask

  function automatic logic model(input int lvl);
    logic [2:0] md;
    int h, v, f;
    md = sh[0][lvl][18:16];
    h = md[0] ? hc % 3 : hc % 4;
    v = md[1] ? vc % 3 : vc % 4;
    f = md[2] ? fc % 3 : fc % 4;
    return sh[f][lvl][v*4 + h];
  endfunction

  task automatic wr(input int bank, input int lvl, input logic [31:0] d, input logic [1:0] lo);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {bank[1:0], lvl[2:0], lo}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    sh[bank][lvl] = d;
  endtask

  task automatic wr_all(input int lvl, input logic [31:0] d0, input logic [31:0] d1,
                        input logic [31:0] d2, input logic [31:0] d3);
    wr(0, lvl, d0, 2'b00); wr(1, lvl, d1, 2'b00);
    wr(2, lvl, d2, 2'b00); wr(3, lvl, d3, 2'b00);
  endtask

  task automatic pixel(input int lvl, input string req);
    logic exp;
    @(negedge clk);
    exp = model(lvl);
    pix_valid = 1'b1; pix_val = lvl[2:0];
    @(negedge clk);
    pix_valid = 1'b0;
    check(req, pix_on, exp);
    hc++;
  endtask

  task automatic eol();
    @(negedge clk); line_end = 1'b1;
    @(negedge clk); line_end = 1'b0;
    hc = 0; vc++;
  endtask

  task automatic eof();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    fc++;
  endtask

  task automatic t_reset();
    check("R1", pix_on, 1'b0);
    pixel(6, "R1");
    pixel(3, "R1");
  endtask

  task automatic t_idle();
    wr_all(7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    pixel(7, "R2");
    @(negedge clk);
    check("R2", pix_on, 1'b0);
    @(negedge clk);
    check("R2", pix_on, 1'b0);
  endtask

  task automatic t_horiz();
    wr_all(1, 32'h0000_4444, 32'h0000_4444, 32'h0000_4444, 32'h0000_4444);
    wr_all(2, 32'h0001_2222, 32'h0001_2222, 32'h0001_2222, 32'h0001_2222);
    for (int i = 0; i < 8; i++) pixel(1, "R3");
    eol();
    for (int i = 0; i < 8; i++) pixel(2, "R3");
    eol();
  endtask

  task automatic t_line();
    for (int i = 0; i < 3; i++) pixel(1, "R4");
    eol();
    for (int i = 0; i < 4; i++) pixel(1, "R4");
    eol();
  endtask

  task automatic t_vert();
    wr_all(3, 32'h0002_0F00, 32'hFFF8_0F00, 32'h0006_0F00, 32'h0002_0F00);
    for (int l = 0; l < 7; l++) begin
      pixel(3, "R4");
      pixel(3, "R7");
      eol();
    end
  endtask

  task automatic t_frame();
    wr_all(4, 32'h0000_0000, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000);
    wr_all(5, 32'h0004_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_FFFF);
    for (int fr = 0; fr < 7; fr++) begin
      pixel(4, "R5");
      pixel(5, "R8");
      eof();
    end
  endtask

  task automatic t_extremes();
    wr_all(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    pixel(0, "R11");
    wr(0, 0, 32'h0, 2'b11); wr(1, 0, 32'h0, 2'b01);
    wr(2, 0, 32'h0, 2'b10); wr(3, 0, 32'h0, 2'b11);
    for (int fr = 0; fr < 5; fr++) begin
      for (int l = 0; l < 5; l++) begin
        for (int p = 0; p < 5; p++) begin
          pixel(0, "R9");
          pixel(7, "R10");
        end
        eol();
      end
      eof();
    end
  endtask

  task automatic t_addr();
    wr(2, 6, 32'h0000_FFFF, 2'b11);
    wr(0, 6, 32'h0004_0000, 2'b10);
    for (int fr = 0; fr < 4; fr++) begin
      pixel(6, "R6");
      eof();
    end
  endtask

  initial begin
    for (int b = 0; b < 4; b++)
      for (int l = 0; l < 8; l++)
        sh[b][l] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_horiz();
    t_line();
    t_vert();
    t_frame();
    t_extremes();
    t_addr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule